// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block burns a stream of bytes into a UV-erasable, one-time-per-erase memory device. The device can only clear bits. A host gives a start address and then hands over bytes one at a time. For each byte the sequencer first reads the target location. It refuses the byte if the byte needs a 0 turned back into a 1. Otherwise it places address and data on the pins and raises the high-voltage enable. It then fires a single timed active-low chip-select pulse, releases the voltage in order, and reads the location back to confirm it.

Every wait is a parameter counted in clock cycles, and the defaults suit a 50 MHz clock. The defaults are a 2 µs setup, a 50 ms pulse, a 2 µs hold, a 2 µs recovery, a 1 µs read window and a 140 ns float gap. The block ends each run by raising either a done flag or an error flag. On error it reports the failing address and stops. Switching the high voltage itself is handled outside the block.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset romCeN and romOeN are 1, romVppEn and romDoutEn are 0, and busy, done, err and byteReady are 0.
- R2: A start pulse while idle loads startAddr. Accepted bytes, taken when byteValid and byteReady are both 1 at a clock edge, go to consecutive addresses. byteReady is 0 while the block is idle.
- R3: Before programming, the location is read with romCeN and romOeN low and romVppEn low. If the wanted byte has a 1 in any bit where the read value has a 0, err rises with errAddr set to that address, and no program pulse is issued.
- R4: romVppEn and romDoutEn are 1 for T_SETUP cycles before romCeN falls for programming. romAddr and romDout stay unchanged for as long as romCeN is low with romVppEn high.
- R5: The program pulse holds romCeN low for exactly T_PULSE cycles, with romVppEn at 1 and romOeN at 1.
- R6: After the pulse ends, romVppEn and romDoutEn stay at 1 for T_HOLD cycles before they fall.
- R7: romVppEn stays at 0 for T_RECOVER cycles before romCeN falls for the verify read.
- R8: Each read (blank check or verify) holds romCeN and romOeN low for exactly T_READ cycles, with romVppEn at 0. It samples romDin at the end of that window. romCeN stays high for at least T_FLOAT cycles before the next read starts.
- R9: If the verify value differs from the wanted byte, err rises with errAddr set to that address. The block goes idle and accepts no further bytes.
- R10: When the byte flagged by byteLast verifies correctly, done rises. done and err are never both 1, and each holds until the next start.
- R11: romDoutEn is never 1 while romOeN is 0.
- R12: A byte that only clears more bits of an already programmed location is accepted and programmed, and so is a byte equal to the stored value.

Top module parameters: ADDR_W, DATA_W, T_SETUP, T_PULSE, T_HOLD, T_RECOVER, T_READ, T_FLOAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run at startAddr (used only while idle) |
| startAddr | input | ADDR_W | First address of the run |
| byteValid | input | 1 | Host presents a byte |
| byteData | input | DATA_W | Byte to program |
| byteLast | input | 1 | Presented byte is the final one of the run |
| byteReady | output | 1 | Sequencer takes the presented byte at this edge |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished with every byte verified |
| err | output | 1 | Run stopped on a blank-check or verify failure |
| errAddr | output | ADDR_W | Address of the failing location |
| romAddr | output | ADDR_W | Device address pins |
| romDout | output | DATA_W | Data driven to the device |
| romDoutEn | output | 1 | Drive enable for romDout |
| romDin | input | DATA_W | Data read from the device |
| romCeN | output | 1 | Device chip enable, active low |
| romOeN | output | 1 | Device output enable, active low |
| romVppEn | output | 1 | Request for the programming voltage |

## Verification
The bench models the device. The model clears bits on each pulse, returns valid read data only once the read window has elapsed, and has one location with a stuck bit. A sequencer that samples too early then reads zeros and flags good bytes as illegal. A sequencer that skips the blank check pulses a byte that needs a 0 turned back into 1, which shows up in the pulse count. A sequencer that ignores a verify failure carries on to the next address and raises done. The model also counts setup, pulse, hold, recovery and float windows at the pins, so a timer off by one cycle or a voltage enable dropped together with chip enable is reported against its own requirement.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [2:0] {
    TMR_READ,
    TMR_FLOAT,
    TMR_SETUP,
    TMR_PULSE,
    TMR_HOLD,
    TMR_RECOVER
  } tmrSel_e;

  typedef struct packed {
    logic    loadAddr;
    logic    incAddr;
    logic    takeByte;
    logic    capture;
    logic    markErr;
    logic    tmrLoad;
    tmrSel_e tmrSel;
  } dpCtl_t;

endpackage

// File: rtl/eprom_prog_dp.sv
module eprom_prog_dp
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int T_SETUP   = 100,
  parameter int T_PULSE   = 2500000,
  parameter int T_HOLD    = 100,
  parameter int T_RECOVER = 100,
  parameter int T_READ    = 50,
  parameter int T_FLOAT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteLast,
  input  logic [DATA_W-1:0] romDin,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDout,
  output logic [ADDR_W-1:0] errAddr,
  output logic              lastByte,
  output logic              tmrDone,
  output logic              illegal,
  output logic              mismatch
);

  localparam int T_M1    = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int T_M2    = (T_HOLD > T_RECOVER) ? T_HOLD : T_RECOVER;
  localparam int T_M3    = (T_READ > T_FLOAT) ? T_READ : T_FLOAT;
  localparam int T_M12   = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MAX   = (T_M12 > T_M3) ? T_M12 : T_M3;
  localparam int CNT_W   = $clog2(T_MAX + 1);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wantReg;
  logic [DATA_W-1:0] readReg;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  loadVal;

  always_comb begin
    unique case (ctl.tmrSel)
      TMR_READ:    loadVal = CNT_W'(T_READ - 1);
      TMR_FLOAT:   loadVal = CNT_W'(T_FLOAT - 1);
      TMR_SETUP:   loadVal = CNT_W'(T_SETUP - 1);
      TMR_PULSE:   loadVal = CNT_W'(T_PULSE - 1);
      TMR_HOLD:    loadVal = CNT_W'(T_HOLD - 1);
      TMR_RECOVER: loadVal = CNT_W'(T_RECOVER - 1);
      default:     loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctl.tmrLoad) cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wantReg  <= '0;
      readReg  <= '0;
      errAddr  <= '0;
      lastByte <= 1'b0;
    end else begin
      if (ctl.loadAddr) addrReg <= startAddr;
      else if (ctl.incAddr) addrReg <= addrReg + 1'b1;
      if (ctl.takeByte) begin
        wantReg  <= byteData;
        lastByte <= byteLast;
      end
      if (ctl.capture) readReg <= romDin;
      if (ctl.markErr) errAddr <= addrReg;
    end
  end

  assign tmrDone  = (cnt == '0);
  assign illegal  = |(wantReg & ~readReg);
  assign mismatch = (wantReg != readReg);
  assign romAddr  = addrReg;
  assign romDout  = wantReg;

  AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (tmrDone && !ctl.tmrLoad) |=> tmrDone); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incAddr && !ctl.loadAddr) |=> (addrReg == $past(addrReg) + 1'b1)); // R2

endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_prog_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   byteValid,
  input  logic   tmrDone,
  input  logic   illegal,
  input  logic   mismatch,
  input  logic   lastByte,
  output dpCtl_t ctl,
  output logic   byteReady,
  output logic   busy,
  output logic   done,
  output logic   err,
  output logic   romCeN,
  output logic   romOeN,
  output logic   romVppEn,
  output logic   romDoutEn
);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_PREREAD, S_PREFLOAT, S_SETUP,
    S_PULSE, S_HOLD, S_RECOVER, S_VERIFY, S_VFLOAT
  } state_e;

  state_e st, nxt;
  logic   setErr, setDone, clrFlags;

  always_comb begin
    nxt      = st;
    ctl      = '0;
    setErr   = 1'b0;
    setDone  = 1'b0;
    clrFlags = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        ctl.loadAddr = 1'b1; clrFlags = 1'b1; nxt = S_FETCH;
      end
      S_FETCH: if (byteValid) begin
        ctl.takeByte = 1'b1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TMR_READ; nxt = S_PREREAD;
      end
      S_PREREAD: if (tmrDone) begin
        ctl.capture = 1'b1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TMR_FLOAT; nxt = S_PREFLOAT;
      end
      S_PREFLOAT: if (tmrDone) begin
        if (illegal) begin
          ctl.markErr = 1'b1; setErr = 1'b1; nxt = S_IDLE;
        end else begin
          ctl.tmrLoad = 1'b1; ctl.tmrSel = TMR_SETUP; nxt = S_SETUP;
        end
      end
      S_SETUP: if (tmrDone) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = TMR_PULSE; nxt = S_PULSE;
      end
      S_PULSE: if (tmrDone) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = TMR_HOLD; nxt = S_HOLD;
      end
      S_HOLD: if (tmrDone) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = TMR_RECOVER; nxt = S_RECOVER;
      end
      S_RECOVER: if (tmrDone) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = TMR_READ; nxt = S_VERIFY;
      end
      S_VERIFY: if (tmrDone) begin
        ctl.capture = 1'b1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TMR_FLOAT; nxt = S_VFLOAT;
      end
      S_VFLOAT: if (tmrDone) begin
        if (mismatch) begin
          ctl.markErr = 1'b1; setErr = 1'b1; nxt = S_IDLE;
        end else if (lastByte) begin
          setDone = 1'b1; nxt = S_IDLE;
        end else begin
          ctl.incAddr = 1'b1; nxt = S_FETCH;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      romCeN    <= 1'b1;
      romOeN    <= 1'b1;
      romVppEn  <= 1'b0;
      romDoutEn <= 1'b0;
    end else begin
      st        <= nxt;
      done      <= (done & ~clrFlags) | setDone;
      err       <= (err & ~clrFlags) | setErr;
      romCeN    <= !(nxt == S_PREREAD || nxt == S_PULSE || nxt == S_VERIFY);
      romOeN    <= !(nxt == S_PREREAD || nxt == S_VERIFY);
      romVppEn  <= (nxt == S_SETUP || nxt == S_PULSE || nxt == S_HOLD);
      romDoutEn <= (nxt == S_SETUP || nxt == S_PULSE || nxt == S_HOLD);
    end
  end

  assign byteReady = (st == S_FETCH);
  assign busy      = (st != S_IDLE);

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> !romDoutEn); // R11
  AST_PULSE_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && romVppEn) |-> romOeN); // R5
  AST_VPP_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(romCeN) && $past(romVppEn)) |-> romVppEn); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err)); // R10
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R10
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> (romCeN && !romVppEn)); // R2

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int T_SETUP   = 100,
  parameter int T_PULSE   = 2500000,
  parameter int T_HOLD    = 100,
  parameter int T_RECOVER = 100,
  parameter int T_READ    = 50,
  parameter int T_FLOAT   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteLast,
  output logic              byteReady,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] errAddr,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDout,
  output logic              romDoutEn,
  input  logic [DATA_W-1:0] romDin,
  output logic              romCeN,
  output logic              romOeN,
  output logic              romVppEn
);

  dpCtl_t ctl;
  logic   tmrDone, illegal, mismatch, lastByte;

  eprom_prog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteValid(byteValid),
    .tmrDone(tmrDone), .illegal(illegal), .mismatch(mismatch), .lastByte(lastByte),
    .ctl(ctl), .byteReady(byteReady), .busy(busy), .done(done), .err(err),
    .romCeN(romCeN), .romOeN(romOeN), .romVppEn(romVppEn), .romDoutEn(romDoutEn)
  );

  eprom_prog_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
    .T_HOLD(T_HOLD), .T_RECOVER(T_RECOVER), .T_READ(T_READ), .T_FLOAT(T_FLOAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr), .byteData(byteData),
    .byteLast(byteLast), .romDin(romDin), .romAddr(romAddr), .romDout(romDout),
    .errAddr(errAddr), .lastByte(lastByte), .tmrDone(tmrDone), .illegal(illegal),
    .mismatch(mismatch)
  );

  AST_PINS_STABLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && romVppEn && $past(!romCeN && romVppEn)) |->
      ($stable(romAddr) && $stable(romDout))); // R4

endmodule

// File: tb/sim_eprom_prog_seq.sv
module sim_eprom_prog_seq;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int TS = 4;
  localparam int TP = 20;
  localparam int TH = 3;
  localparam int TR = 5;
  localparam int TRD = 3;
  localparam int TF = 2;
  localparam int NVEC = 7;
  localparam logic [3:0] STUCK_ADDR = 4'd9;
  localparam logic [7:0] STUCK_MASK = 8'h02;

  // {addr, len, seed, expErr, errAddr, expPulses}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'd0,  4'd3, 8'hA5, 1'b0, 4'd0, 4'd3},
    {4'd4,  4'd2, 8'h30, 1'b0, 4'd0, 4'd2},
    {4'd0,  4'd1, 8'h25, 1'b0, 4'd0, 4'd1},
    {4'd4,  4'd1, 8'h70, 1'b1, 4'd4, 4'd0},
    {4'd8,  4'd3, 8'h10, 1'b1, 4'd9, 4'd2},
    {4'd14, 4'd2, 8'hC0, 1'b0, 4'd0, 4'd2},
    {4'd14, 4'd1, 8'hC0, 1'b0, 4'd0, 4'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic byteValid = 1'b0;
  logic [DW-1:0] byteData = '0;
  logic byteLast = 1'b0;
  logic byteReady, busy, done, err, romDoutEn, romCeN, romOeN, romVppEn;
  logic [AW-1:0] errAddr, romAddr;
  logic [DW-1:0] romDout, romDin;

  always #10 clk = ~clk;

  eprom_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
    .T_RECOVER(TR), .T_READ(TRD), .T_FLOAT(TF)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .byteLast(byteLast),
    .byteReady(byteReady), .busy(busy), .done(done), .err(err), .errAddr(errAddr),
    .romAddr(romAddr), .romDout(romDout), .romDoutEn(romDoutEn), .romDin(romDin),
    .romCeN(romCeN), .romOeN(romOeN), .romVppEn(romVppEn)
  );

  // device model
  logic [7:0] mem [16];
  int vppOn = 0, vppOff = 1000, ceLow = 0, ceHigh = 1000, pulses = 0;
  int vSetup = 0, vPulse = 0, vHold = 0, vRecover = 0, vRead = 0, vCont = 0, vStable = 0;
  logic prevCeN = 1'b1, prevVpp = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevDout = '0;

  assign romDin = (!romCeN && !romOeN && !romVppEn && ceLow >= TRD) ? mem[romAddr] : 8'h00;

  initial for (int k = 0; k < 16; k++) mem[k] = 8'hFF;

  always @(negedge clk) if (rstN) begin
    if (romDoutEn && !romOeN) vCont++;
    if (prevCeN && !romCeN && romVppEn && vppOn < TS) vSetup++;
    if (prevCeN && !romCeN && !romVppEn) begin
      if (vppOff < TR) vRecover++;
      if (ceHigh < TF) vRead++;
    end
    if (!prevCeN && romCeN && romVppEn) begin
      if (ceLow != TP) vPulse++;
      mem[prevAddr] = mem[prevAddr] & (prevDout | ((prevAddr == STUCK_ADDR) ? STUCK_MASK : 8'h00));
      pulses++;
    end
    if (!prevCeN && romCeN && !romVppEn && !prevVpp && ceLow != TRD) vRead++;
    if (prevVpp && !romVppEn && (ceHigh < TH || romDoutEn)) vHold++;
    if (!romCeN && !prevCeN && romVppEn && (romAddr != prevAddr || romDout != prevDout)) vStable++;
    vppOn  = romVppEn ? vppOn + 1 : 0;
    vppOff = romVppEn ? 0 : vppOff + 1;
    ceLow  = romCeN ? 0 : ceLow + 1;
    ceHigh = romCeN ? ceHigh + 1 : 0;
    prevCeN = romCeN; prevVpp = romVppEn; prevAddr = romAddr; prevDout = romDout;
  end

  int nChk = 0, nFail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic runCase(input logic [24:0] v, output int taken);
    logic [3:0] a; logic [3:0] n; logic [7:0] s;
    int i;
    a = v[24:21]; n = v[20:17]; s = v[16:9];
    @(negedge clk); start = 1'b1; startAddr = a;
    @(negedge clk); start = 1'b0;
    i = 0;
    while (i < n && busy) begin
      byteValid = 1'b1; byteData = s + 8'(i); byteLast = (i == n - 1);
      #1;
      if (byteReady) begin
        @(posedge clk); i++;
      end
      @(negedge clk);
    end
    byteValid = 1'b0; byteLast = 1'b0;
    while (busy) @(negedge clk);
    taken = i;
  endtask

  initial begin
    int p0, taken, errIdx;
    logic [3:0] a; logic [3:0] n; logic [7:0] s;
    repeat (3) @(negedge clk);
    chk(romCeN && romOeN && !romVppEn && !romDoutEn, "R1 pins in reset",
        {romCeN, romOeN, romVppEn, romDoutEn}, 4'b1100);
    chk(!busy && !done && !err && !byteReady, "R1 flags in reset",
        {busy, done, err, byteReady}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!byteReady, "R2 ready low when idle", byteReady, 0);

    for (int c = 0; c < NVEC; c++) begin
      a = VEC[c][24:21]; n = VEC[c][20:17]; s = VEC[c][16:9];
      errIdx = VEC[c][8] ? int'(VEC[c][7:4] - a) : n;
      p0 = pulses;
      runCase(VEC[c], taken);
      chk(err == VEC[c][8], "R3/R9 err flag", err, VEC[c][8]);
      chk(done == !VEC[c][8], "R10 done flag", done, !VEC[c][8]);
      if (VEC[c][8]) chk(errAddr == VEC[c][7:4], "R3/R9 errAddr", errAddr, VEC[c][7:4]);
      chk(pulses - p0 == int'(VEC[c][3:0]), "R3 pulse count", pulses - p0, VEC[c][3:0]);
      chk(taken == (VEC[c][8] ? errIdx + 1 : n), "R2 bytes taken", taken,
          VEC[c][8] ? errIdx + 1 : n);
      for (int i = 0; i < n; i++) begin
        if (i < errIdx)
          chk(mem[4'(a + i)] == 8'(s + i), "R2/R12 stored byte", mem[4'(a + i)], 8'(s + i));
        else if (i > errIdx)
          chk(mem[4'(a + i)] == 8'hFF, "R9 untouched after error", mem[4'(a + i)], 8'hFF);
      end
      repeat (4) @(negedge clk);
      chk((done == !VEC[c][8]) && (err == VEC[c][8]) && !byteReady,
          "R10 flags held while idle", {done, err, byteReady}, {!VEC[c][8], VEC[c][8], 1'b0});
    end

    chk(mem[4] == 8'h30, "R3 refused byte left location unchanged", mem[4], 8'h30);
    chk(mem[0] == 8'h25, "R12 extra zeros programmed", mem[0], 8'h25);
    chk(mem[9] == 8'h13, "R9 stuck cell value", mem[9], 8'h13);
    chk(vSetup == 0, "R4 setup window", vSetup, 0);
    chk(vStable == 0, "R4 pins stable in pulse", vStable, 0);
    chk(vPulse == 0, "R5 pulse width", vPulse, 0);
    chk(vHold == 0, "R6 hold window", vHold, 0);
    chk(vRecover == 0, "R7 recovery window", vRecover, 0);
    chk(vRead == 0, "R8 read and float windows", vRead, 0);
    chk(vCont == 0, "R11 no bus contention", vCont, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule